// File: doc/BRIEF.md
# GPIO Port Register Block with Atomic Set/Clear/Toggle Aliases

This block is the register front end of a 30-pin general purpose I/O bank. It hangs on a simple 32-bit register bus with an address, a write strobe, write data, a read strobe and registered read data. It holds two pieces of state. One is the driven output level of each pin. The other is the per-pin output enable. It also offers a synchronized view of the pin levels and a read-only identifier for the processor core.

Each of the two state registers is reached through four word offsets. One offset loads the register outright. The other three change only the bits that are 1 in the write data: they set them, clear them or invert them, all in a single bus cycle. Software can therefore change its own pins without a read-modify-write sequence, and without disturbing pins that another agent owns.

Top module: `pinbank_regs`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `pin_out` and `pin_oe` are all zero, so every pin is an input.
- R2: A write to offset 0x10 (output) or 0x20 (output enable) replaces that register with write data bits 29..0. Bits 31..30 of the write data are dropped, and bits 31..30 of every read except the core identifier read as zero.
- R3: A write to offset 0x14 (output) or 0x24 (enable) sets every register bit whose write data bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x18 (output) or 0x28 (enable) clears every register bit whose write data bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0x1C (output) or 0x2C (enable) inverts every register bit whose write data bit is 1 and leaves the other bits unchanged.
- R6: Any write to the output or enable group shows on `pin_out` or `pin_oe` at the clock edge that accepts it, and the register holds its value in every cycle without such a write.
- R7: A read of any of the four offsets in a group (0x10 to 0x1C, or 0x20 to 0x2C) returns the current value of that group's register.
- R8: A read of offset 0x04 returns `pin_in` after a two-flop synchronizer. A level that changes just before clock edge k is returned by a read accepted at edge k+2 or later. A read accepted at edge k or k+1 still returns the old level.
- R9: A read of offset 0x00 returns `core_id` on all 32 bits. Writes to 0x00, 0x04, to any offset outside the ten mapped ones, and to any offset whose two low bits are not zero change neither register.
- R10: A read of an unmapped offset (including an offset that is not word aligned) returns zero.
- R11: `bus_rdata` is registered. It changes at the edge after `bus_re` and shows state from before any write accepted at the same edge. It is zero after any cycle in which `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| core_id | input | 32 | Static core identifier |
| pin_in | input | 30 | Asynchronous pin levels |
| pin_out | output | 30 | Output level per pin |
| pin_oe | output | 30 | Output enable per pin |

## Verification
The assertions assume that a write is a single-cycle strobe, with address and data stable while `bus_we` is high. They also assume that `core_id` does not change. The bench drives all bus inputs on the falling edge, holds `core_id` constant, and returns the strobes to zero between accesses. The bench is the only source that moves `pin_in` asynchronously. Because a read can arrive in the same cycle as a write, the read-data checks assume the old-value ordering of R11. The bench covers this with a combined read and write.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD,
    OP_SET,
    OP_CLR,
    OP_XOR
  } upd_op_e;

  typedef enum logic [2:0] {
    RS_ZERO,
    RS_ID,
    RS_IN,
    RS_OUT,
    RS_OE
  } rd_src_e;

  // word indices (byte offset / 4) of the mapped locations
  localparam int unsigned WIDX_ID  = 0;
  localparam int unsigned WIDX_IN  = 1;
  localparam int unsigned WIDX_OUT = 4;  // 4..7  : load, set, clear, toggle
  localparam int unsigned WIDX_OE  = 8;  // 8..11 : load, set, clear, toggle

  // alias index within a group picks the update operation
  function automatic upd_op_e alias_to_op(input logic [1:0] sel);
    case (sel)
      2'd0:    return OP_LOAD;
      2'd1:    return OP_SET;
      2'd2:    return OP_CLR;
      default: return OP_XOR;
    endcase
  endfunction

  // bitwise update rule applied by every register group
  function automatic logic [29:0] apply_op(input upd_op_e op,
                                           input logic [29:0] cur,
                                           input logic [29:0] wd);
    case (op)
      OP_LOAD: return wd;
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      OP_XOR:  return cur ^ wd;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int unsigned WIDTH  = 30,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pinbank_decode.sv
module pinbank_decode
  import pinbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output upd_op_e           out_op,
  output upd_op_e           oe_op,
  output rd_src_e           rd_src,
  output logic              wr_ignored,
  output logic              rd_unmapped
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] widx;
  logic              aligned;
  logic              hit_out;
  logic              hit_oe;

  assign widx    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign hit_out = aligned && (widx >= WORD_W'(WIDX_OUT)) && (widx < WORD_W'(WIDX_OUT + 4));
  assign hit_oe  = aligned && (widx >= WORD_W'(WIDX_OE))  && (widx < WORD_W'(WIDX_OE + 4));

  always_comb begin
    out_op = OP_NONE;
    oe_op  = OP_NONE;
    if (we && hit_out) out_op = alias_to_op(addr[3:2]);
    if (we && hit_oe)  oe_op  = alias_to_op(addr[3:2]);
  end

  always_comb begin
    rd_src = RS_ZERO;
    if (aligned && widx == WORD_W'(WIDX_ID))      rd_src = RS_ID;
    else if (aligned && widx == WORD_W'(WIDX_IN)) rd_src = RS_IN;
    else if (hit_out)                             rd_src = RS_OUT;
    else if (hit_oe)                              rd_src = RS_OE;
  end

  assign wr_ignored  = we && !hit_out && !hit_oe;
  assign rd_unmapped = (rd_src == RS_ZERO);
endmodule

// File: rtl/pinbank_reg.sv
module pinbank_reg
  import pinbank_pkg::*;
#(
  parameter int unsigned WIDTH = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  upd_op_e          op,
  input  logic [WIDTH-1:0] wd,
  output logic [WIDTH-1:0] value
);
  logic [WIDTH-1:0] value_q;
  logic [29:0]      next_full;

  assign next_full = apply_op(op, 30'(value_q), 30'(wd));

  always_ff @(posedge clk) begin
    if (!rst_n)             value_q <= '0;
    else if (op != OP_NONE) value_q <= next_full[WIDTH-1:0];
  end

  assign value = value_q;

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET) |=> (value_q == ($past(value_q) | $past(wd))));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR) |=> (value_q == ($past(value_q) & ~$past(wd))));
  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XOR) |=> (value_q == ($past(value_q) ^ $past(wd))));
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (value_q == $past(wd)));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE) |=> $stable(value_q));
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int unsigned PIN_COUNT   = 30,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_re,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [DATA_W-1:0]    core_id,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe
);
  localparam int unsigned PAD_W = DATA_W - PIN_COUNT;

  upd_op_e              out_op;
  upd_op_e              oe_op;
  rd_src_e              rd_src;
  logic                 wr_ignored;
  logic                 rd_unmapped;
  logic [PIN_COUNT-1:0] wd_pins;
  logic [PIN_COUNT-1:0] in_sync;
  logic [DATA_W-1:0]    rd_mux;

  assign wd_pins = bus_wdata[PIN_COUNT-1:0];

  pinbank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr        (bus_addr),
    .we          (bus_we),
    .out_op      (out_op),
    .oe_op       (oe_op),
    .rd_src      (rd_src),
    .wr_ignored  (wr_ignored),
    .rd_unmapped (rd_unmapped)
  );

  pinbank_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (in_sync)
  );

  pinbank_reg #(.WIDTH(PIN_COUNT)) u_out (
    .clk (clk), .rst_n (rst_n), .op (out_op), .wd (wd_pins), .value (pin_out)
  );

  pinbank_reg #(.WIDTH(PIN_COUNT)) u_oe (
    .clk (clk), .rst_n (rst_n), .op (oe_op), .wd (wd_pins), .value (pin_oe)
  );

  always_comb begin
    case (rd_src)
      RS_ID:   rd_mux = core_id;
      RS_IN:   rd_mux = {{PAD_W{1'b0}}, in_sync};
      RS_OUT:  rd_mux = {{PAD_W{1'b0}}, pin_out};
      RS_OE:   rd_mux = {{PAD_W{1'b0}}, pin_oe};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  assert_ignored_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> ($stable(pin_out) && $stable(pin_oe)));
  assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && rd_unmapped) |=> (bus_rdata == '0));
  assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == '0));
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && rd_src != RS_ID) |=> (bus_rdata[DATA_W-1:PIN_COUNT] == '0));
  assert_one_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_op != OP_NONE && oe_op != OP_NONE));
endmodule

// File: tb/sim_pinbank_regs.sv
module sim_pinbank_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] core_id = 32'hC0DE_0001;
  logic [29:0] pin_in = '0;
  logic [29:0] pin_out;
  logic [29:0] pin_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;  // 250 MHz

  pinbank_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .core_id(core_id), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // behavioural reference model
  int unsigned m_out = 0, m_oe = 0, m_rd = 0;
  int unsigned m_sync [$] = '{0, 0};
  localparam int unsigned MASK = 32'h3FFF_FFFF;

  always @(posedge clk) begin
    int unsigned a, rd;
    a = bus_addr;
    if (!rst_n) begin
      m_out = 0; m_oe = 0; m_rd = 0; m_sync = '{0, 0};
    end else begin
      rd = 0;
      if (bus_re) begin
        if (a == 0)                   rd = core_id;
        else if (a == 4)              rd = m_sync[1];
        else if (a >= 16 && a <= 28 && a % 4 == 0) rd = m_out;
        else if (a >= 32 && a <= 44 && a % 4 == 0) rd = m_oe;
      end
      if (bus_we && a % 4 == 0) begin
        case (a)
          16: m_out = bus_wdata & MASK;
          20: m_out = m_out | (bus_wdata & MASK);
          24: m_out = m_out & ~bus_wdata;
          28: m_out = (m_out ^ bus_wdata) & MASK;
          32: m_oe  = bus_wdata & MASK;
          36: m_oe  = m_oe | (bus_wdata & MASK);
          40: m_oe  = m_oe & ~bus_wdata;
          44: m_oe  = (m_oe ^ bus_wdata) & MASK;
          default: ;
        endcase
      end
      m_rd = rd;
      m_sync.push_front(int'(pin_in));
      void'(m_sync.pop_back());
    end
  end

  task automatic check(string req, string what, int unsigned act, int unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "pin_out vs model", pin_out, m_out);
      check(cur_req, "pin_oe vs model", pin_oe, m_oe);
      check(cur_req, "rdata vs model", bus_rdata, m_rd);
    end
  end

  task automatic wr(input int unsigned a, input int unsigned d);
    bus_addr = 8'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int unsigned a, output int unsigned v);
    bus_addr = 8'(a); bus_re = 1'b1;
    @(negedge clk);
    v = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    int unsigned v;
    @(negedge clk);
    check("R1", "out in reset", pin_out, 0);
    check("R1", "oe in reset", pin_oe, 0);
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out after reset", pin_out, 0);
    check("R1", "oe after reset", pin_oe, 0);

    cur_req = "R2";
    wr(16, 32'hFFFF_FFFF);
    check("R6", "pin_out updated at write edge", pin_out, 32'h3FFF_FFFF);
    rd(16, v); check("R2", "base load drops bits 31..30", v, 32'h3FFF_FFFF);
    wr(16, 32'h0000_00F0);
    rd(16, v); check("R2", "base load replaces", v, 32'h0000_00F0);

    cur_req = "R3";
    wr(20, 32'h0000_000F);
    check("R3", "set alias", pin_out, 32'h0000_00FF);
    cur_req = "R4";
    wr(24, 32'h0000_0030);
    check("R4", "clear alias", pin_out, 32'h0000_00CF);
    cur_req = "R5";
    wr(28, 32'hC000_0FF0);
    check("R5", "toggle alias", pin_out, 32'h0000_0F3F);
    cur_req = "R7";
    rd(28, v); check("R7", "read of toggle alias", v, 32'h0000_0F3F);
    rd(20, v); check("R7", "read of set alias", v, 32'h0000_0F3F);

    cur_req = "R3";
    wr(32, 32'h2000_0001);
    wr(36, 32'h0000_0100);
    check("R3", "oe set alias", pin_oe, 32'h2000_0101);
    check("R6", "out untouched by oe writes", pin_out, 32'h0000_0F3F);
    cur_req = "R4";
    wr(40, 32'hFFFF_FFFE);
    check("R4", "oe clear alias", pin_oe, 32'h0000_0001);
    cur_req = "R5";
    wr(44, 32'h0000_0003);
    check("R5", "oe toggle alias", pin_oe, 32'h0000_0002);
    rd(40, v); check("R7", "read of oe clear alias", v, 32'h0000_0002);
    idle(3);
    check("R6", "out holds when idle", pin_out, 32'h0000_0F3F);

    cur_req = "R9";
    rd(0, v); check("R9", "core id", v, 32'hC0DE_0001);
    wr(0, 32'h1234_5678);
    wr(4, 32'h1234_5678);
    wr(48, 32'h1234_5678);
    wr(17, 32'hFFFF_FFFF);
    wr(22, 32'hFFFF_FFFF);
    wr(252, 32'hFFFF_FFFF);
    check("R9", "out after ignored writes", pin_out, 32'h0000_0F3F);
    check("R9", "oe after ignored writes", pin_oe, 32'h0000_0002);

    cur_req = "R10";
    rd(48, v);  check("R10", "unmapped read", v, 0);
    rd(18, v);  check("R10", "unaligned read", v, 0);
    rd(8, v);   check("R10", "gap read", v, 0);

    cur_req = "R8";
    pin_in = 30'h2AAA_5555;
    idle(2);
    rd(4, v); check("R8", "synced input", v, 32'h2AAA_5555);
    pin_in = 30'h0000_1234;
    rd(4, v); check("R8", "read at change edge still old", v, 32'h2AAA_5555);
    rd(4, v); check("R8", "read one edge later still old", v, 32'h2AAA_5555);
    rd(4, v); check("R8", "read two edges later new", v, 32'h0000_1234);

    cur_req = "R11";
    bus_addr = 8'd16; bus_wdata = 32'h0000_0055; bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    check("R11", "read with same-edge write gives old", bus_rdata, 32'h0000_0F3F);
    check("R11", "write still applied", pin_out, 32'h0000_0055);
    @(negedge clk);
    check("R11", "rdata zero when idle", bus_rdata, 0);

    cur_req = "R5";
    for (int i = 0; i < 40; i++) begin
      wr(20 + 4 * (i % 3), (i * 32'h0137_9BDF) ^ 32'h5A5A_A5A5);
      wr(36 + 4 * ((i + 1) % 3), i * 32'h0F0F_1357);
      pin_in = 30'(i * 32'h0765_4321);
      rd(16 + 4 * (i % 8) * ((i % 2) + 1), v);
    end
    idle(3);
    finish_run();
  end
endmodule